// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block turns parallel left and right audio samples into a single serial data line. It follows a bit clock and a left/right (frame) clock that come from outside. Both clocks are sampled in the system clock domain through a short synchronizer. The data line changes only after a falling bit-clock edge, so a receiver can take each bit on the next rising edge.

Five framing conventions are selectable:

- Standard I2S, with a one-slot delay after the channel transition.
- Left-aligned.
- Right-aligned.
- Two frame-sync variants, where both words follow each other after a rising sync pulse. One variant starts one slot after the pulse, the other starts on it.

The word length is 16, 20, 24 or 32 bits.

Samples arrive through a ready/valid handshake into a holding register that stores one stereo pair. At each frame start the pair in that register becomes the pair being sent. If the register is empty at a frame start, the previous pair is sent again and an underrun flag is raised.

Top module: `aud_serial_tx`

## Requirements
- R1: `sd` changes only in response to a detected falling edge of `bclk`, and holds its value while `bclk` is high.
- R2: With `fmt` = 0 (I2S), the MSB is driven in the slot after each `lrclk` transition. The left word is sent while `lrclk` is low and the right word while it is high. When a half lasts exactly one word, the LSB occupies the transition slot that follows.
- R3: With `fmt` = 1 (left-aligned), the MSB is driven in the transition slot itself. Channel polarity is the same as in R2.
- R4: With `fmt` = 2 (right-aligned), the LSB occupies the last slot of the half. The half length is taken from the previous half of the same polarity. The line stays low in a half until a length for that polarity has been measured.
- R5: With `fmt` = 3 (frame sync, late), the left word and then the right word are sent with the MSB one slot after the rising `lrclk` slot. In a frame of exactly two words, the right LSB falls in the next rising slot.
- R6: With `fmt` = 4 (frame sync, early), the left MSB is driven in the rising `lrclk` slot, followed directly by the right word.
- R7: `wlen` selects the word length: 0 = 16, 1 = 20, 2 = 24, 3 = 32 bits. Samples are LSB-aligned in `s_left` and `s_right`, and bits above the word length have no effect on `sd`.
- R8: `sd` is low in every slot not occupied by a word bit, and low before the first frame start.
- R9: `sd` stays low for `fmt` codes 5 to 7, and for `fmt` = 2 combined with `wlen` = 3.
- R10: `s_ready` is high exactly when the one-pair holding register is empty. An accepted pair is sent in the next frame. A frame starts at a falling `lrclk` transition in modes 0 to 2 and at a rising one in modes 3 and 4.
- R11: At a frame start with an empty holding register, the previous pair is sent again (zeros after reset) and `underrun` goes high. `underrun` is updated only at frame starts.
- R12: After reset `sd` = 0, `underrun` = 0 and `s_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Bit clock, sampled through the synchronizer |
| lrclk | input | 1 | Channel / frame sync clock, sampled the same way |
| fmt | input | 3 | Framing mode code (R2 to R6, R9) |
| wlen | input | 2 | Word length code (R7) |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding register empty |
| s_left | input | DW | Left sample, LSB-aligned |
| s_right | input | DW | Right sample, LSB-aligned |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Last frame start found no new pair |

## Verification
The slot counter, the measured half lengths and the holding register can each go wrong internally. A wrong slot counter or a wrong half length shows up as a word shifted by one or more slots. That shift is visible at `sd` within the first word after the bad value, because a reference model compares every slot both before the rising bit-clock edge and during the high phase. A lost or duplicated pair shows up as the wrong sample or a wrong `underrun` level in the frame that follows. The boundary cases are halves and frames exactly one or two words long (the wrap into the next transition slot), unequal half lengths in right-aligned mode, and the modes that must stay silent.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

   typedef enum logic [2:0] {
      FMT_I2S      = 3'd0,
      FMT_LEFT     = 3'd1,
      FMT_RIGHT    = 3'd2,
      FMT_FS_LATE  = 3'd3,
      FMT_FS_EARLY = 3'd4
   } fmt_e;

   localparam int unsigned WORD_MAX = 32;

   function automatic int unsigned word_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 16;
         2'd1:    return 20;
         2'd2:    return 24;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/aud_tx_sync.sv
module aud_tx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= (q << 1) | STAGES'(din);
         end
         assign dout = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/aud_tx_timing.sv
module aud_tx_timing #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bclk_s,
   input  logic          lr_s,
   input  logic          is_dsp,
   output logic          fall_ev,
   output logic          ref_ev,
   output logic          frame_ev,
   output logic [CW-1:0] k,
   output logic [CW-1:0] prev_len,
   output logic          seen,
   output logic          synced_now,
   output logic [CW-1:0] len_cur
);
   logic          bclk_q, primed, lr_q, seen_q, synced_q, trans;
   logic [CW-1:0] cnt, inc, len_lo, len_hi;

   assign fall_ev    = bclk_q & ~bclk_s;
   assign trans      = fall_ev & primed & (lr_s != lr_q);
   assign ref_ev     = trans & (~is_dsp | lr_s);
   assign frame_ev   = trans & (is_dsp ? lr_s : ~lr_s);
   assign inc        = (&cnt) ? cnt : cnt + 1'b1;
   assign k          = ref_ev ? '0 : inc;
   assign prev_len   = inc;
   assign seen       = seen_q;
   assign synced_now = synced_q | frame_ev;
   assign len_cur    = lr_s ? len_hi : len_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q   <= 1'b0;
         primed   <= 1'b0;
         lr_q     <= 1'b0;
         seen_q   <= 1'b0;
         synced_q <= 1'b0;
         cnt      <= '0;
         len_lo   <= '0;
         len_hi   <= '0;
      end else begin
         bclk_q <= bclk_s;
         if (fall_ev) begin
            primed <= 1'b1;
            lr_q   <= lr_s;
            cnt    <= k;
            if (ref_ev) seen_q <= 1'b1;
            if (ref_ev && seen_q && !is_dsp) begin
               if (lr_q) len_hi <= inc;
               else      len_lo <= inc;
            end
            if (frame_ev) synced_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/aud_tx_store.sv
module aud_tx_store #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          s_valid,
   input  logic [DW-1:0] s_left,
   input  logic [DW-1:0] s_right,
   input  logic          frame_ev,
   output logic          s_ready,
   output logic [DW-1:0] cur_l,
   output logic [DW-1:0] cur_r,
   output logic [DW-1:0] nxt_l,
   output logic [DW-1:0] nxt_r,
   output logic          underrun
);
   logic          hold_v;
   logic [DW-1:0] hold_l, hold_r;

   assign s_ready = ~hold_v;
   assign nxt_l   = hold_v ? hold_l : cur_l;
   assign nxt_r   = hold_v ? hold_r : cur_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v   <= 1'b0;
         hold_l   <= '0;
         hold_r   <= '0;
         cur_l    <= '0;
         cur_r    <= '0;
         underrun <= 1'b0;
      end else begin
         if (frame_ev) begin
            cur_l    <= nxt_l;
            cur_r    <= nxt_r;
            underrun <= ~hold_v;
         end
         if (s_valid && !hold_v) begin
            hold_v <= 1'b1;
            hold_l <= s_left;
            hold_r <= s_right;
         end else if (frame_ev) begin
            hold_v <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/aud_tx_bitsel.sv
module aud_tx_bitsel
   import aud_tx_pkg::*;
#(
   parameter int DW = 32,
   parameter int CW = 8
) (
   input  logic [2:0]    fmt,
   input  logic [1:0]    wlen,
   input  logic [CW-1:0] k,
   input  logic [CW-1:0] prev_len,
   input  logic [CW-1:0] len_cur,
   input  logic          seen,
   input  logic          lr,
   input  logic          frame_ev,
   input  logic          synced_now,
   input  logic [DW-1:0] cur_l,
   input  logic [DW-1:0] cur_r,
   input  logic [DW-1:0] nxt_l,
   input  logic [DW-1:0] nxt_r,
   output logic          bit_o
);
   function automatic logic pick(input logic [DW-1:0] w, input logic [CW-1:0] idx);
      logic r;
      r = 1'b0;
      for (int i = 0; i < DW; i++)
         if (idx == CW'(i)) r = w[i];
      return r;
   endfunction

   logic [CW-1:0] wl, wl2, km1, p, ridx;
   logic [DW-1:0] use_l, use_r, word;
   logic          b, late;

   always_comb begin
      wl    = CW'(word_bits(wlen));
      wl2   = wl << 1;
      km1   = k - 1'b1;
      use_l = frame_ev ? nxt_l : cur_l;
      use_r = frame_ev ? nxt_r : cur_r;
      word  = lr ? use_r : use_l;
      late  = (fmt == FMT_FS_LATE);
      p     = late ? km1 : k;
      ridx  = len_cur - k - 1'b1;
      b     = 1'b0;
      case (fmt)
         FMT_I2S: begin
            if (k == '0)
               b = seen && (prev_len == wl) && (lr ? cur_l[0] : cur_r[0]);
            else if (km1 < wl)
               b = pick(word, wl - km1 - 1'b1);
         end
         FMT_LEFT: begin
            if (k < wl) b = pick(word, wl - k - 1'b1);
         end
         FMT_RIGHT: begin
            if (wlen != 2'd3 && len_cur != '0 && k < len_cur && ridx < wl)
               b = pick(word, ridx);
         end
         FMT_FS_LATE, FMT_FS_EARLY: begin
            if (late && k == '0)
               b = seen && (prev_len == wl2) && cur_r[0];
            else if (p < wl)
               b = pick(use_l, wl - p - 1'b1);
            else if (p < wl2)
               b = pick(use_r, wl2 - p - 1'b1);
         end
         default: b = 1'b0;
      endcase
      bit_o = synced_now & b;
   end
endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
   import aud_tx_pkg::*;
#(
   parameter int DW   = 32,
   parameter int CW   = 8,
   parameter int SYNC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bclk,
   input  logic          lrclk,
   input  logic [2:0]    fmt,
   input  logic [1:0]    wlen,
   input  logic          s_valid,
   output logic          s_ready,
   input  logic [DW-1:0] s_left,
   input  logic [DW-1:0] s_right,
   output logic          sd,
   output logic          underrun
);
   generate
      if (DW < int'(WORD_MAX)) begin : g_bad_dw
         $error("aud_serial_tx: DW must hold the longest word");
      end
      if (CW < 7) begin : g_bad_cw
         $error("aud_serial_tx: CW too small to count two longest words");
      end
   endgenerate

   logic          bclk_s, lr_s, is_dsp;
   logic          fall_ev, ref_ev, frame_ev, seen, synced_now, bit_nx;
   logic [CW-1:0] k, prev_len, len_cur;
   logic [DW-1:0] cur_l, cur_r, nxt_l, nxt_r;

   assign is_dsp = (fmt == FMT_FS_LATE) || (fmt == FMT_FS_EARLY);

   aud_tx_sync #(.STAGES(SYNC)) u_sync_b (.clk(clk), .rst_n(rst_n), .din(bclk),  .dout(bclk_s));
   aud_tx_sync #(.STAGES(SYNC)) u_sync_l (.clk(clk), .rst_n(rst_n), .din(lrclk), .dout(lr_s));

   aud_tx_timing #(.CW(CW)) u_timing (
      .clk(clk), .rst_n(rst_n), .bclk_s(bclk_s), .lr_s(lr_s), .is_dsp(is_dsp),
      .fall_ev(fall_ev), .ref_ev(ref_ev), .frame_ev(frame_ev), .k(k),
      .prev_len(prev_len), .seen(seen), .synced_now(synced_now), .len_cur(len_cur)
   );

   aud_tx_store #(.DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
      .frame_ev(frame_ev), .s_ready(s_ready), .cur_l(cur_l), .cur_r(cur_r),
      .nxt_l(nxt_l), .nxt_r(nxt_r), .underrun(underrun)
   );

   aud_tx_bitsel #(.DW(DW), .CW(CW)) u_bitsel (
      .fmt(fmt), .wlen(wlen), .k(k), .prev_len(prev_len), .len_cur(len_cur),
      .seen(seen), .lr(lr_s), .frame_ev(frame_ev), .synced_now(synced_now),
      .cur_l(cur_l), .cur_r(cur_r), .nxt_l(nxt_l), .nxt_r(nxt_r), .bit_o(bit_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sd <= 1'b0;
      else if (fall_ev) sd <= bit_nx;
   end

   logic unused_ref;
   assign unused_ref = ref_ev;
endmodule

// File: rtl/aud_serial_tx_chk.sv
module aud_serial_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sd,
   input logic       underrun,
   input logic       s_valid,
   input logic       s_ready,
   input logic [2:0] fmt,
   input logic [1:0] wlen,
   input logic       fall_ev,
   input logic       frame_ev,
   input logic       synced_now
);
   // R1
   sd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sd) |-> $past(fall_ev));

   // R11
   und_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(underrun) |-> $past(frame_ev));

   // R10
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |=> !s_ready);

   // R9
   rj32_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_ev && fmt == 3'd2 && wlen == 2'd3) |=> !sd);

   // R9
   bad_fmt_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_ev && fmt >= 3'd5) |=> !sd);

   // R8
   presync_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !synced_now |-> !sd);
endmodule

bind aud_serial_tx aud_serial_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sd(sd), .underrun(underrun),
   .s_valid(s_valid), .s_ready(s_ready), .fmt(fmt), .wlen(wlen),
   .fall_ev(fall_ev), .frame_ev(frame_ev), .synced_now(synced_now)
);

// File: tb/aud_serial_tx_tb_top.sv
module aud_serial_tx_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b1, lrclk = 1'b1;
   logic [2:0]  fmt = 3'd0;
   logic [1:0]  wlen = 2'd0;
   logic        s_valid = 1'b0;
   logic [31:0] s_left = '0, s_right = '0;
   logic        s_ready, sd, underrun;

   int nchecks = 0, nerr = 0;
   logic [31:0] feed_l[$], feed_r[$];
   bit pend = 0;

   always #5 clk = ~clk;

   aud_serial_tx dut_i (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .fmt(fmt), .wlen(wlen),
      .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
      .sd(sd), .underrun(underrun)
   );

   // producer of sample pairs through the handshake
   initial forever begin
      @(negedge clk);
      if (!rst_n) begin
         pend = 0;
         s_valid = 1'b0;
      end else begin
         if (pend) begin
            void'(feed_l.pop_front());
            void'(feed_r.pop_front());
            pend = 0;
         end
         if (feed_l.size() > 0) begin
            s_valid = 1'b1;
            s_left  = feed_l[0];
            s_right = feed_r[0];
         end else begin
            s_valid = 1'b0;
         end
         pend = s_valid && s_ready;
      end
   end

   task automatic check(input string tag, input logic act, input logic exp);
      nchecks++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic run_case(input logic [2:0] f_v, input logic [1:0] w_v, input int lo,
                           input int hi, input int nfr, input int npairs, input string tag);
      int W, N, s;
      bit dsp;
      bit meas[2];
      logic [31:0] pl[$], pr[$];
      bit lrs[$], un[$], ex[$], used[$];
      logic [31:0] wl_, wr_;
      W   = (w_v == 2'd3) ? 32 : 16 + 4 * int'(w_v);
      dsp = (f_v == 3'd3) || (f_v == 3'd4);
      for (int i = 0; i < npairs; i++) begin
         pl.push_back($urandom);
         pr.push_back($urandom);
      end
      if (!dsp) begin
         for (int i = 0; i < hi; i++) begin lrs.push_back(1); un.push_back(0); end
         for (int f = 0; f < nfr; f++) begin
            for (int i = 0; i < lo; i++) begin lrs.push_back(0); un.push_back(f >= npairs); end
            for (int i = 0; i < hi; i++) begin lrs.push_back(1); un.push_back(f >= npairs); end
         end
      end else begin
         for (int i = 0; i < 3; i++) begin lrs.push_back(0); un.push_back(0); end
         for (int f = 0; f < nfr; f++) begin
            lrs.push_back(1); un.push_back(f >= npairs);
            for (int i = 1; i < lo; i++) begin lrs.push_back(0); un.push_back(f >= npairs); end
         end
      end
      N = lrs.size();
      for (int i = 0; i < N; i++) begin ex.push_back(0); used.push_back(0); end
      meas[0] = 0; meas[1] = 0;
      for (int f = 0; f < nfr; f++) begin
         wl_ = (npairs == 0) ? 32'd0 : pl[(f < npairs) ? f : npairs - 1];
         wr_ = (npairs == 0) ? 32'd0 : pr[(f < npairs) ? f : npairs - 1];
         if (!dsp) begin
            for (int h = 0; h < 2; h++) begin
               int L, st, pos;
               logic [31:0] w;
               L  = h ? hi : lo;
               st = hi + f * (lo + hi) + (h ? lo : 0);
               w  = h ? wr_ : wl_;
               for (int i = 0; i < W; i++) begin
                  pos = -1;
                  if (f_v == 3'd0) pos = st + 1 + i;
                  else if (f_v == 3'd1) pos = st + i;
                  else if (f_v == 3'd2 && W != 32 && meas[h]) pos = st + L - W + i;
                  if (pos >= 0 && pos < N) begin ex[pos] = w[W-1-i]; used[pos] = 1; end
               end
               meas[h] = 1;
            end
         end else if (f_v == 3'd3 || f_v == 3'd4) begin
            s = 3 + f * lo + ((f_v == 3'd3) ? 1 : 0);
            for (int i = 0; i < W; i++) begin
               if (s + i < N)     begin ex[s+i]   = wl_[W-1-i]; used[s+i]   = 1; end
               if (s + W + i < N) begin ex[s+W+i] = wr_[W-1-i]; used[s+W+i] = 1; end
            end
         end
      end
      // reset with the mode applied
      @(negedge clk);
      rst_n = 1'b0; bclk = 1'b1; lrclk = lrs[0]; fmt = f_v; wlen = w_v;
      @(negedge clk);
      feed_l.delete(); feed_r.delete();
      for (int i = 0; i < npairs; i++) begin feed_l.push_back(pl[i]); feed_r.push_back(pr[i]); end
      repeat (2) @(negedge clk);
      check("R12 sd", sd, 1'b0);
      check("R12 underrun", underrun, 1'b0);
      check("R12 s_ready", s_ready, 1'b1);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R10 s_ready after load", s_ready, (npairs > 0) ? 1'b0 : 1'b1);
      for (int t = 0; t < N; t++) begin
         bclk = 1'b0;
         lrclk = lrs[t];
         repeat (4) @(negedge clk);
         check((used[t] || tag == "R9") ? tag : "R8", sd, ex[t]);
         check("R11", underrun, un[t]);
         bclk = 1'b1;
         repeat (2) @(negedge clk);
         check("R1", sd, ex[t]);
         repeat (2) @(negedge clk);
      end
   endtask

   initial begin
      run_case(3'd0, 2'd2, 32, 32, 3, 3, "R2/R7");   // I2S 24-bit, roomy halves
      run_case(3'd0, 2'd0, 16, 16, 3, 3, "R2/R7");   // I2S 16-bit, LSB wraps into transition
      run_case(3'd1, 2'd1, 24, 28, 3, 3, "R3/R7");   // left-aligned 20-bit, unequal halves
      run_case(3'd2, 2'd0, 20, 24, 3, 3, "R4/R7");   // right-aligned 16-bit
      run_case(3'd2, 2'd3, 34, 34, 2, 2, "R9");      // right-aligned 32-bit not allowed
      run_case(3'd3, 2'd0, 32, 0, 3, 3, "R5/R7");    // sync late, frame of two words
      run_case(3'd4, 2'd2, 56, 0, 3, 3, "R6/R7");    // sync early, 24-bit
      run_case(3'd1, 2'd3, 34, 34, 4, 2, "R11");     // repeat after pairs run out
      run_case(3'd0, 2'd0, 18, 18, 2, 0, "R11");     // no pair ever: zeros, flag high
      run_case(3'd5, 2'd0, 20, 20, 2, 2, "R9");      // unused mode code
      $display("  CHECKS %0d ERRORS %0d", nchecks, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchecks++;
      nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", nchecks, nerr);
      $finish;
   end
endmodule